// File: doc/BRIEF.md
# USB device interrupt controller

This block gathers the event sources of a full-speed USB peripheral into one 24-bit interrupt status word and drives an active-low interrupt pin toward the host processor. The event sources are per-endpoint transfer completions, bus reset, suspend, resume, start-of-frame, end-of-transfer and a setup-packet end-of-transfer. The serial engine issues each of these as a one-cycle strobe, and only after the packet has been acknowledged. A built-in frame watchdog adds a pseudo start-of-frame source. Each source has its own enable bit, a global enable gates the pin, and a mode bit selects a level or a pulse output.

The frame watchdog counts a 12 MHz clock-enable. Every real start-of-frame restarts it. When a frame passes with no start-of-frame, it raises a pseudo start-of-frame. When three frames in a row are missed, it raises suspend. Firmware clears bits with read strobes. A read of the status word clears the bus-event bits. An endpoint bit clears only when that endpoint's own status register is read. All control and status pins are plain signals. There is no streaming interface, so no back-pressure applies.

Top module: `usb_irq_ctrl`

## Requirements
- R1: A `stat_rd` strobe clears status bits 16 (bus reset), 17 (suspend), 18 (resume), 19 (start-of-frame), 20 (pseudo start-of-frame), 21 (end-of-transfer) and 22 (setup end-of-transfer) at the next clock edge.
- R2: Status bits 0..15 hold endpoint events in this order: bit 0 endpoint 0 OUT, bit 1 endpoint 0 IN, bit n endpoint n-1 for n = 2..15. A bit clears only on `ep_rd[n]`. A `stat_rd` strobe leaves it set.
- R3: Status bit 23 shows `bus_live` combinationally. It is never latched.
- R4: After a real start-of-frame, if no further start-of-frame arrives, bit 20 sets on the 12000th `tick_12m` pulse. Each further missed frame of 12000 ticks sets it again.
- R5: On the third missed frame in a row, bit 17 (suspend) sets and the watchdog stops until the next real start-of-frame. A real start-of-frame resets the miss count to zero.
- R6: If an event strobe and a clearing read for the same bit fall in one cycle, the bit ends up set.
- R7: `int_n` is driven low only if the global enable is set and some latched bit has its enable bit set. The enable bits are `en_wdata[22:0]`, at the same positions as the status bits.
- R8: In level mode (`mode_pulse`=0), `int_n` goes low one cycle after an enabled bit latches. It stays low until no enabled bit remains.
- R9: In pulse mode, each newly pending enabled bit drives `int_n` low for exactly 4 cycles, starting one cycle after the bit latches.
- R10: Synchronous active-high `rst` clears all status bits, the frame watchdog, the enable mask and the global enable.
- R11: An event strobe sets its status bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_12m | input | 1 | 12 MHz clock-enable for the frame watchdog |
| ev_bus_reset | input | 1 | Bus reset seen |
| ev_suspend | input | 1 | Bus idle suspend seen by serial engine |
| ev_resume | input | 1 | Resume signalling seen |
| ev_sof | input | 1 | Real start-of-frame token received |
| ev_eot | input | 1 | End-of-transfer |
| ev_setup_eot | input | 1 | Setup-packet end-of-transfer |
| ep_evt | input | 16 | Per-endpoint acknowledged-transfer strobes |
| bus_live | input | 1 | Live bus status |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 23 | New enable mask |
| mode_we | input | 1 | Write strobe for mode bits |
| mode_gie | input | 1 | Global interrupt enable |
| mode_pulse | input | 1 | 1 = pulse output, 0 = level output |
| stat_rd | input | 1 | Read strobe of the status word |
| ep_rd | input | 16 | Read strobes of endpoint status registers |
| stat_q | output | 24 | Status word |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
The latch update and the clearing reads can land in the same cycle. The bench drives a start-of-frame strobe and an endpoint-5 strobe together with `stat_rd` and `ep_rd[5]` on one falling edge. Before that, it has latched resume so that the read has something to clear. After the next edge, start-of-frame and endpoint 5 must still read as set, while resume must read as cleared. A second overlap occurs in pulse mode: a new enabled source becomes pending while an older one is still latched, and this must produce a fresh 4-cycle pulse.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NUM_EP  = 16;
  localparam int B_RST   = 16;
  localparam int B_SUSP  = 17;
  localparam int B_RESM  = 18;
  localparam int B_SOF   = 19;
  localparam int B_PSOF  = 20;
  localparam int B_EOT   = 21;
  localparam int B_SPEOT = 22;
  localparam int NSRC    = 23;
  localparam int STAT_W  = NSRC + 1;
  localparam logic [NSRC-1:0] EP_MASK  = {{(NSRC-NUM_EP){1'b0}}, {NUM_EP{1'b1}}};
  localparam logic [NSRC-1:0] BUS_MASK = ~EP_MASK;
endpackage

// File: rtl/usb_irq_frame_timer.sv
module usb_irq_frame_timer #(
  parameter int TICKS_PER_FRAME = 12000,
  parameter int MISS_LIMIT      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sof,
  output logic psof_o,
  output logic miss_susp_o
);
  localparam int CW = $clog2(TICKS_PER_FRAME);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [MW-1:0] miss_q;
  logic          armed_q;

  assign psof_o      = armed_q && tick && !sof && (cnt_q == CW'(TICKS_PER_FRAME - 1));
  assign miss_susp_o = psof_o && (miss_q == MW'(MISS_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      miss_q  <= '0;
      armed_q <= 1'b0;
    end else if (sof) begin
      cnt_q   <= '0;
      miss_q  <= '0;
      armed_q <= 1'b1;
    end else if (psof_o) begin
      cnt_q <= '0;
      if (miss_susp_o) begin
        miss_q  <= '0;
        armed_q <= 1'b0;
      end else begin
        miss_q <= miss_q + 1'b1;
      end
    end else if (armed_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: a real start-of-frame re-arms and zeroes the miss count
  a_r5_sof_rearm: assert property (@(posedge clk) disable iff (rst)
    sof |=> (armed_q && miss_q == '0));
  // R5: reaching the miss limit parks the watchdog
  a_r5_park: assert property (@(posedge clk) disable iff (rst)
    (miss_susp_o && !sof) |=> !armed_q);
  // R5: miss count never reaches the limit while armed
  a_r5_miss_bound: assert property (@(posedge clk) disable iff (rst)
    miss_q < MW'(MISS_LIMIT));
  // R4: a pseudo tick restarts the frame count
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    psof_o |=> (cnt_q == '0));
endmodule

// File: rtl/usb_irq_latch_bank.sv
module usb_irq_latch_bank
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   set_vec,
  input  logic              stat_rd,
  input  logic [NUM_EP-1:0] ep_rd,
  output logic [NSRC-1:0]   lat_q
);
  logic [NSRC-1:0] clr_vec;

  always_comb begin
    clr_vec = {NSRC{stat_rd}} & BUS_MASK;
    clr_vec[NUM_EP-1:0] = ep_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= (lat_q & ~clr_vec) | set_vec;
  end

  // R6 / R11: every strobed source is set after the edge
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((lat_q & $past(set_vec)) == $past(set_vec)));
  // R2: endpoint bits survive when no endpoint read is strobed
  a_r2_ep_hold: assert property (@(posedge clk) disable iff (rst)
    (ep_rd == '0) |=> ((lat_q & $past(lat_q) & EP_MASK) == ($past(lat_q) & EP_MASK)));
  // R1: a status read with no new bus events empties the bus-event bits
  a_r1_bus_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && ((set_vec & BUS_MASK) == '0)) |=> ((lat_q & BUS_MASK) == '0));
endmodule

// File: rtl/usb_irq_out_drv.sv
module usb_irq_out_drv
  import usb_irq_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] active_vec,
  input  logic            gie,
  input  logic            pulse_mode,
  output logic            int_n
);
  localparam int PW = $clog2(PULSE_W + 1);

  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] new_bits;
  logic [PW-1:0]   pcnt_q;

  assign new_bits = active_vec & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pcnt_q <= '0;
      int_n  <= 1'b1;
    end else begin
      prev_q <= active_vec;
      if (!gie) begin
        pcnt_q <= '0;
        int_n  <= 1'b1;
      end else if (!pulse_mode) begin
        pcnt_q <= '0;
        int_n  <= ~(|active_vec);
      end else if (|new_bits) begin
        pcnt_q <= PW'(PULSE_W - 1);
        int_n  <= 1'b0;
      end else if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
        int_n  <= 1'b0;
      end else begin
        int_n  <= 1'b1;
      end
    end
  end

  // R7: pin is released whenever the global enable is off
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    !gie |=> int_n);
  // R7: no enabled pending source in level mode means a quiet pin
  a_r7_level_idle: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode && active_vec == '0) |=> int_n);
  // R8: level mode follows any enabled pending source
  a_r8_level_low: assert property (@(posedge clk) disable iff (rst)
    (gie && !pulse_mode && (|active_vec)) |=> !int_n);
  // R9: a new enabled source in pulse mode starts a low pulse
  a_r9_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (gie && pulse_mode && (|new_bits)) |=> !int_n);
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int TICKS_PER_FRAME = 12000,
  parameter int MISS_LIMIT      = 3,
  parameter int PULSE_W         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_12m,
  input  logic              ev_bus_reset,
  input  logic              ev_suspend,
  input  logic              ev_resume,
  input  logic              ev_sof,
  input  logic              ev_eot,
  input  logic              ev_setup_eot,
  input  logic [NUM_EP-1:0] ep_evt,
  input  logic              bus_live,
  input  logic              en_we,
  input  logic [NSRC-1:0]   en_wdata,
  input  logic              mode_we,
  input  logic              mode_gie,
  input  logic              mode_pulse,
  input  logic              stat_rd,
  input  logic [NUM_EP-1:0] ep_rd,
  output logic [STAT_W-1:0] stat_q,
  output logic              int_n
);
  logic [NSRC-1:0] mask_q;
  logic            gie_q;
  logic            pulse_q;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] lat_q;
  logic            psof;
  logic            miss_susp;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      gie_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (en_we) mask_q <= en_wdata;
      if (mode_we) begin
        gie_q   <= mode_gie;
        pulse_q <= mode_pulse;
      end
    end
  end

  usb_irq_frame_timer #(
    .TICKS_PER_FRAME(TICKS_PER_FRAME),
    .MISS_LIMIT     (MISS_LIMIT)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_12m),
    .sof        (ev_sof),
    .psof_o     (psof),
    .miss_susp_o(miss_susp)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[NUM_EP-1:0]  = ep_evt;
    set_vec[B_RST]       = ev_bus_reset;
    set_vec[B_SUSP]      = ev_suspend | miss_susp;
    set_vec[B_RESM]      = ev_resume;
    set_vec[B_SOF]       = ev_sof;
    set_vec[B_PSOF]      = psof;
    set_vec[B_EOT]       = ev_eot;
    set_vec[B_SPEOT]     = ev_setup_eot;
  end

  usb_irq_latch_bank u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .stat_rd(stat_rd),
    .ep_rd  (ep_rd),
    .lat_q  (lat_q)
  );

  assign stat_q = {bus_live, lat_q};

  usb_irq_out_drv #(.PULSE_W(PULSE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .active_vec(lat_q & mask_q),
    .gie       (gie_q),
    .pulse_mode(pulse_q),
    .int_n     (int_n)
  );

  // R10: reset empties the mask, the global enable and every latch
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && !gie_q && lat_q == '0));
  // R3: the bus-status bit mirrors the live input
  always_comb a_r3_live: assert (stat_q[STAT_W-1] == bus_live);
endmodule

// File: tb/usb_irq_ctrl_tb_top.sv
module usb_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_12m = 1'b1;
  logic        ev_bus_reset = 0, ev_suspend = 0, ev_resume = 0, ev_sof = 0;
  logic        ev_eot = 0, ev_setup_eot = 0;
  logic [15:0] ep_evt = '0;
  logic        bus_live = 0;
  logic        en_we = 0;
  logic [22:0] en_wdata = '0;
  logic        mode_we = 0, mode_gie = 0, mode_pulse = 0;
  logic        stat_rd = 0;
  logic [15:0] ep_rd = '0;
  logic [23:0] stat_q;
  logic        int_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  usb_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .tick_12m(tick_12m),
    .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend), .ev_resume(ev_resume),
    .ev_sof(ev_sof), .ev_eot(ev_eot), .ev_setup_eot(ev_setup_eot),
    .ep_evt(ep_evt), .bus_live(bus_live), .en_we(en_we), .en_wdata(en_wdata),
    .mode_we(mode_we), .mode_gie(mode_gie), .mode_pulse(mode_pulse),
    .stat_rd(stat_rd), .ep_rd(ep_rd), .stat_q(stat_q), .int_n(int_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_stat();
    stat_rd = 1; step(); stat_rd = 0;
  endtask

  task automatic set_mode(input logic [22:0] m, input logic g, input logic p);
    en_we = 1; en_wdata = m; mode_we = 1; mode_gie = g; mode_pulse = p;
    step();
    en_we = 0; mode_we = 0;
  endtask

  task automatic t_reset_state();
    chk("R10 status after reset", {8'h0, stat_q}, 32'h0);
    chk("R10 int_n after reset", {31'h0, int_n}, 32'h1);
  endtask

  task automatic t_bus_clear();
    ev_bus_reset = 1; ev_eot = 1; ep_evt[3] = 1;
    step();
    ev_bus_reset = 0; ev_eot = 0; ep_evt = '0;
    chk("R11 events latched", {8'h0, stat_q & 24'h21_0008}, 32'h0021_0008);
    read_stat();
    chk("R1 bus bits cleared by status read", {31'h0, stat_q[16] | stat_q[21]}, 32'h0);
    chk("R2 endpoint 3 kept over status read", {31'h0, stat_q[3]}, 32'h1);
    ep_rd[2] = 1; step(); ep_rd = '0;
    chk("R2 other endpoint read leaves bit 3", {31'h0, stat_q[3]}, 32'h1);
    ep_rd[3] = 1; step(); ep_rd = '0;
    chk("R2 endpoint 3 cleared by own read", {31'h0, stat_q[3]}, 32'h0);
  endtask

  task automatic t_live();
    bus_live = 1; #1;
    chk("R3 bus bit high", {31'h0, stat_q[23]}, 32'h1);
    read_stat();
    chk("R3 bus bit not cleared by read", {31'h0, stat_q[23]}, 32'h1);
    bus_live = 0; #1;
    chk("R3 bus bit low", {31'h0, stat_q[23]}, 32'h0);
  endtask

  task automatic t_collide();
    ev_resume = 1; step(); ev_resume = 0;
    ev_sof = 1; ep_evt[5] = 1; stat_rd = 1; ep_rd[5] = 1;
    step();
    ev_sof = 0; ep_evt = '0; stat_rd = 0; ep_rd = '0;
    chk("R6 sof kept over read", {31'h0, stat_q[19]}, 32'h1);
    chk("R6 endpoint 5 kept over read", {31'h0, stat_q[5]}, 32'h1);
    chk("R1 resume cleared in same read", {31'h0, stat_q[18]}, 32'h0);
    stat_rd = 1; ep_rd[5] = 1; step(); stat_rd = 0; ep_rd = '0;
  endtask

  task automatic t_level();
    set_mode(23'h20_0000, 1'b1, 1'b0);
    ev_resume = 1; step(); ev_resume = 0; step();
    chk("R7 masked source leaves pin high", {31'h0, int_n}, 32'h1);
    ev_eot = 1; step(); ev_eot = 0;
    chk("R8 pin not yet low at latch edge", {31'h0, int_n}, 32'h1);
    step();
    chk("R8 level low", {31'h0, int_n}, 32'h0);
    step();
    chk("R8 level stays low", {31'h0, int_n}, 32'h0);
    mode_we = 1; mode_gie = 0; mode_pulse = 0; step(); mode_we = 0; step();
    chk("R7 global enable off releases pin", {31'h0, int_n}, 32'h1);
    mode_we = 1; mode_gie = 1; step(); mode_we = 0; step();
    chk("R7 global enable on drives pin", {31'h0, int_n}, 32'h0);
    read_stat(); step();
    chk("R8 pin released after clear", {31'h0, int_n}, 32'h1);
  endtask

  task automatic t_pulse();
    int lows;
    set_mode(23'h24_0000, 1'b1, 1'b1);
    ev_eot = 1; step(); ev_eot = 0;
    chk("R9 pulse not yet at latch edge", {31'h0, int_n}, 32'h1);
    lows = 0;
    for (int i = 0; i < 4; i++) begin step(); if (!int_n) lows++; end
    chk("R9 pulse low for 4 cycles", lows, 4);
    step();
    chk("R9 pulse ends after 4", {31'h0, int_n}, 32'h1);
    step(); step();
    chk("R9 pending source does not hold pin", {31'h0, int_n}, 32'h1);
    ev_resume = 1; step(); ev_resume = 0;
    lows = 0;
    for (int i = 0; i < 4; i++) begin step(); if (!int_n) lows++; end
    step();
    chk("R9 second source fresh pulse", {lows, 31'h0, int_n}, {32'd4, 31'h0, 1'b1});
    read_stat();
    set_mode(23'h0, 1'b0, 1'b0);
  endtask

  task automatic t_frame();
    ev_sof = 1; step(); ev_sof = 0;
    read_stat();
    repeat (11998) step();
    chk("R4 no pseudo tick before 12000", {31'h0, stat_q[20]}, 32'h0);
    step();
    chk("R4 pseudo tick at 12000", {31'h0, stat_q[20]}, 32'h1);
    read_stat();
    repeat (11999) step();
    chk("R4 second pseudo tick", {30'h0, stat_q[20], stat_q[17]}, 32'h2);
    read_stat();
    repeat (11999) step();
    chk("R5 suspend on third miss", {30'h0, stat_q[20], stat_q[17]}, 32'h3);
    read_stat();
    repeat (12100) step();
    chk("R5 watchdog parked after suspend", {31'h0, stat_q[20]}, 32'h0);
    ev_sof = 1; step(); ev_sof = 0;
    repeat (23999) step();
    ev_sof = 1; stat_rd = 1; step(); ev_sof = 0; stat_rd = 0;
    repeat (24000) step();
    chk("R5 miss count restarted by sof", {30'h0, stat_q[20], stat_q[17]}, 32'h2);
    repeat (12000) step();
    chk("R5 suspend after three fresh misses", {31'h0, stat_q[17]}, 32'h1);
    read_stat();
  endtask

  task automatic t_reset_again();
    set_mode(23'h7f_ffff, 1'b1, 1'b0);
    ev_eot = 1; step(); ev_eot = 0; step();
    chk("R8 pin low before reset", {31'h0, int_n}, 32'h0);
    rst = 1; step(); rst = 0;
    chk("R10 status cleared by reset", {8'h0, stat_q}, 32'h0);
    chk("R10 pin released by reset", {31'h0, int_n}, 32'h1);
    ev_eot = 1; step(); ev_eot = 0; step();
    chk("R10 mask and enable cleared", {30'h0, stat_q[21], int_n}, 32'h3);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset_state();
    t_bus_clear();
    t_live();
    t_collide();
    t_level();
    t_pulse();
    t_frame();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule